// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog timer with an 8-bit up-counter, a timer control register and a reset status register, all placed on a simple synchronous register bus. The counter and the control register are written through one shared write address. A write to that address only takes effect when it is a full 16-bit word write and its upper byte holds the key of the target register. The new register value comes from the lower byte. This protects the timer against stray or partial writes.

The counter advances on each tick of an external prescaler input while the control register's run bit is set. When the counter wraps from its maximum value to zero in watchdog mode, the block sets a sticky overflow flag and returns the counter and the control register to zero. If reset generation is enabled, it also drives a fixed-length internal reset pulse. Software can clear the flag only by reading it as 1 and then writing 0 to it.

Top module: `wdt_keyed`

## Requirements
- R1: A word write (`bus_word`=1) to address 0 whose upper byte is 0x5A loads the counter with the lower byte. The counter reads back at address 1, in `bus_rdata[7:0]`, with the upper byte 0.
- R2: A word write to address 0 whose upper byte is 0xA5 loads the control register with the lower byte. The control register reads back at address 0 with the upper byte 0. Control bit 5 is the run bit and control bit 6 selects watchdog mode.
- R3: A byte write (`bus_word`=0) to address 0 changes neither the counter nor the control register. A word write to address 0 with any upper byte other than 0x5A or 0xA5 also changes neither register.
- R4: While run is 1, each cycle with `tick_in`=1 increments the counter by one. While run is 0, ticks leave the counter unchanged.
- R5: In watchdog mode, a tick while the counter is 0xFF sets the overflow flag, which reads at address 2 bit 7. In interval mode (control bit 6 = 0), the counter wraps to 0x00 without setting the flag.
- R6: A write to address 2 with data bit 7 = 0 clears the overflow flag only if the flag was read as 1 at address 2 (with `bus_rd`=1) beforehand. Without that read, the flag stays set.
- R7: Address 2 bit 6 is the reset enable and is written from data bit 6 by any write to address 2. When it is 1, a watchdog-mode overflow drives `wdt_rst_o` high for exactly PULSE_LEN cycles, starting in the cycle that follows the overflow edge.
- R8: When the reset enable is 0, a watchdog-mode overflow leaves `wdt_rst_o` low. In both cases, the overflow returns the counter and the control register to 0x00.
- R9: Reads at address 2 return bit 5 as 0 and bits 4..0 as 1, whatever was written. Reads at address 3 return 0.
- R10: After reset, the control register reads 0x00, the counter reads 0x00, address 2 reads 0x1F and `wdt_rst_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_word | input | 1 | 1 = word-wide write, 0 = byte-wide write |
| bus_wdata | input | 16 | Write data: key in the upper byte, value in the lower byte |
| bus_rd | input | 1 | Read strobe, used to arm flag clearing |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| tick_in | input | 1 | Count enable tick from the prescaler |
| wdt_rst_o | output | 1 | Internal reset pulse |

## Verification
The bench walks every counter and control value through the keyed path. It then sweeps all 256 upper-byte values at the shared address, which catches a decoder that accepts a wrong key, checks only some key bits, or lets byte writes through. It writes 0 to a set flag without a prior read, which exposes a flag that clears on any zero write. It then clears the flag the proper way, which exposes a flag that can never clear. It measures the reset pulse width cycle by cycle, catching an off-by-one pulse counter. It also checks that overflow with reset disabled produces no pulse, that interval-mode wrap raises no flag, and that the address 2 reserved bits read back fixed across all 256 written values.

// File: rtl/wdt_pkg.sv
// Package: shared constants of the keyed watchdog timer.
// Assumes a 16-bit register bus with keys in the upper byte.
package wdt_pkg;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_KEYED = 2'd0; // shared write, control read
    localparam logic [ADDR_W-1:0] ADDR_CNT   = 2'd1; // counter read
    localparam logic [ADDR_W-1:0] ADDR_RSTS  = 2'd2; // reset status

    localparam logic [BYTE_W-1:0] KEY_CNT  = 8'h5A;
    localparam logic [BYTE_W-1:0] KEY_CTRL = 8'hA5;

    localparam int CTRL_RUN  = 5;
    localparam int CTRL_WD   = 6;
    localparam int RSTS_FLAG = 7;
    localparam int RSTS_EN   = 6;

    localparam logic [4:0] RSTS_ONES = 5'h1F;
endpackage

// File: rtl/wdt_bus_decode.sv
// Module: wdt_bus_decode
// Turns bus strobes into per-register write and read pulses.
// Writes to the shared address need a word access and a valid key.
// Assumes the bus holds its signals stable for one clock per access.
module wdt_bus_decode
    import wdt_pkg::*;
(
    input  logic              bus_wr,
    input  logic              bus_word,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] key_byte,
    output logic              cnt_wr,
    output logic              ctrl_wr,
    output logic              rsts_wr,
    output logic              rsts_rd
);
    logic keyed_word;

    // Purpose: qualify a word write to the shared address.
    always_comb keyed_word = bus_wr && bus_word && (bus_addr == ADDR_KEYED);

    // Purpose: choose the target register by key.
    always_comb begin
        cnt_wr  = keyed_word && (key_byte == KEY_CNT);
        ctrl_wr = keyed_word && (key_byte == KEY_CTRL);
        rsts_wr = bus_wr && (bus_addr == ADDR_RSTS);
        rsts_rd = bus_rd && (bus_addr == ADDR_RSTS);
    end
endmodule

// File: rtl/wdt_count.sv
// Module: wdt_count
// Loadable up-counter with a wrap indication.
// Priority is clear, then load, then increment.
// Assumes clr and load are single-cycle pulses.
module wdt_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Purpose: flag a tick arriving at the top count.
    always_comb wrap = inc && (cnt == CNT_MAX);

    // Purpose: count register.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (load) cnt <= load_val;
        else if (inc)  cnt <= cnt + 1'b1;
    end

    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && !clr) |=> (cnt == $past(cnt) + 1'b1));
    p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load && !clr) |=> $stable(cnt));
endmodule

// File: rtl/wdt_status.sv
// Module: wdt_status
// Holds the overflow flag, the reset enable and the clear arming state.
// The flag clears only after it was read as 1 and then written as 0.
// Assumes set_ovf takes precedence over a clear in the same cycle.
module wdt_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_ovf,
    input  logic       wr,
    input  logic       rd,
    input  logic [1:0] wdata_hi,  // [1] flag write, [0] enable write
    output logic       flag,
    output logic       rst_en
);
    logic armed;
    logic do_clear;

    // Purpose: a zero written to an armed flag clears it.
    always_comb do_clear = wr && armed && !wdata_hi[1];

    // Purpose: overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (set_ovf)  flag <= 1'b1;
        else if (do_clear) flag <= 1'b0;
    end

    // Purpose: remember a read that saw the flag set.
    always_ff @(posedge clk) begin
        if (!rst_n)          armed <= 1'b0;
        else if (set_ovf)    armed <= 1'b0;
        else if (do_clear)   armed <= 1'b0;
        else if (rd && flag) armed <= 1'b1;
    end

    // Purpose: reset enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)  rst_en <= 1'b0;
        else if (wr) rst_en <= wdata_hi[0];
    end

    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_ovf |=> flag);
    p_flag_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !armed) |=> flag);
endmodule

// File: rtl/wdt_pulse.sv
// Module: wdt_pulse
// Stretches a trigger into an output pulse of PULSE_LEN cycles.
// The pulse starts the cycle after the trigger; a new trigger restarts it.
module wdt_pulse #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    localparam int PW = $clog2(PULSE_LEN + 1);
    localparam logic [PW-1:0] LEN_V = PW'(PULSE_LEN);

    logic [PW-1:0] left_q;

    // Purpose: count down the remaining pulse cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)              left_q <= '0;
        else if (trig)           left_q <= LEN_V;
        else if (left_q != '0)   left_q <= left_q - 1'b1;
    end

    // Purpose: drive the pulse while cycles remain.
    always_comb pulse = (left_q != '0);

    p_pulse_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> pulse);
    p_pulse_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (left_q <= LEN_V));
endmodule

// File: rtl/wdt_keyed.sv
// Module: wdt_keyed (top)
// Watchdog timer with keyed word writes, a sticky overflow flag and
// an optional internal reset pulse. A watchdog overflow zeroes the
// counter and the control register.
// Assumes tick_in is a one-cycle enable from an external prescaler.
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_word,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_in,
    output logic              wdt_rst_o
);
    logic              cnt_wr, ctrl_wr, rsts_wr, rsts_rd;
    logic [BYTE_W-1:0] ctrl_q;
    logic [BYTE_W-1:0] cnt;
    logic              wrap, inc, ovf_wd;
    logic              flag, rst_en;

    wdt_bus_decode u_dec (
        .bus_wr   (bus_wr),
        .bus_word (bus_word),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .key_byte (bus_wdata[DATA_W-1:BYTE_W]),
        .cnt_wr   (cnt_wr),
        .ctrl_wr  (ctrl_wr),
        .rsts_wr  (rsts_wr),
        .rsts_rd  (rsts_rd)
    );

    // Purpose: ticks count only while running; overflow matters in watchdog mode.
    always_comb begin
        inc    = tick_in && ctrl_q[CTRL_RUN];
        ovf_wd = wrap && ctrl_q[CTRL_WD];
    end

    // Purpose: control register with watchdog-overflow clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ovf_wd)  ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= bus_wdata[BYTE_W-1:0];
    end

    wdt_count #(.CNT_W(BYTE_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ovf_wd),
        .load     (cnt_wr),
        .load_val (bus_wdata[BYTE_W-1:0]),
        .inc      (inc),
        .cnt      (cnt),
        .wrap     (wrap)
    );

    wdt_status u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ovf  (ovf_wd),
        .wr       (rsts_wr),
        .rd       (rsts_rd),
        .wdata_hi (bus_wdata[RSTS_FLAG:RSTS_EN]),
        .flag     (flag),
        .rst_en   (rst_en)
    );

    wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pls (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (ovf_wd && rst_en),
        .pulse (wdt_rst_o)
    );

    // Purpose: read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_KEYED: bus_rdata[BYTE_W-1:0] = ctrl_q;
            ADDR_CNT:   bus_rdata[BYTE_W-1:0] = cnt;
            ADDR_RSTS:  bus_rdata[BYTE_W-1:0] = {flag, rst_en, 1'b0, RSTS_ONES};
            default:    bus_rdata = '0;
        endcase
    end

    p_byte_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_word && bus_addr == ADDR_KEYED && !ovf_wd) |=> $stable(ctrl_q));
    p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cnt_wr, ctrl_wr}));
    p_no_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_wd && !rst_en && !wdt_rst_o) |=> !wdt_rst_o);
    p_wd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_wd |=> (ctrl_q == '0 && cnt == '0));
    p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_RSTS) |-> (bus_rdata[5:0] == 6'h1F));
endmodule

// File: tb/test_wdt_keyed.sv
module test_wdt_keyed;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_word = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic        tick_in = 1'b0;
    logic        wdt_rst_o;

    int total = 0;
    int fails = 0;
    bit timed_out = 1'b0;

    localparam int PLEN = 4;

    wdt_keyed #(.PULSE_LEN(PLEN)) i_wdt_keyed (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .tick_in(tick_in), .wdt_rst_o(wdt_rst_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic word, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_word = word; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_in = 1'b1;
            @(negedge clk); tick_in = 1'b0;
        end
    endtask

    task automatic run_all();
        logic [15:0] d;
        int width;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R10 reset state
        rd(2'd0, d); check("R10 ctrl", d, 16'h0000);
        rd(2'd1, d); check("R10 cnt", d, 16'h0000);
        rd(2'd2, d); check("R10 rsts", d, 16'h001F);
        check("R10 rst_o", {15'b0, wdt_rst_o}, 16'h0000);

        // R1 counter load sweep
        for (int v = 0; v < 256; v++) begin
            wr(2'd0, 1'b1, {8'h5A, 8'(v)});
            rd(2'd1, d); check("R1 counter load", d, {8'h00, 8'(v)});
        end
        // R2 control load sweep
        for (int v = 0; v < 256; v++) begin
            wr(2'd0, 1'b1, {8'hA5, 8'(v)});
            rd(2'd0, d); check("R2 control load", d, {8'h00, 8'(v)});
        end

        // R3 wrong keys and byte writes
        wr(2'd0, 1'b1, 16'h5A33);
        wr(2'd0, 1'b1, 16'hA512);
        for (int k = 0; k < 256; k++) begin
            if (k == 8'h5A || k == 8'hA5) continue;
            wr(2'd0, 1'b1, {8'(k), 8'hC4});
            rd(2'd0, d); check("R3 bad key ctrl", d, 16'h0012);
            rd(2'd1, d); check("R3 bad key cnt", d, 16'h0033);
        end
        wr(2'd0, 1'b0, 16'h5A77);
        rd(2'd1, d); check("R3 byte write cnt", d, 16'h0033);
        wr(2'd0, 1'b0, 16'hA577);
        rd(2'd0, d); check("R3 byte write ctrl", d, 16'h0012);

        // R9 reserved bits across all written values
        for (int v = 0; v < 256; v++) begin
            wr(2'd2, 1'b1, {8'h00, 8'(v)});
            rd(2'd2, d); check("R9 rsts readback", d, {8'h00, 1'b0, v[6], 6'h1F});
        end
        rd(2'd3, d); check("R9 unused addr", d, 16'h0000);
        wr(2'd2, 1'b1, 16'h0000);

        // R4 hold while stopped, increment while running
        wr(2'd0, 1'b1, 16'hA500);
        wr(2'd0, 1'b1, 16'h5A10);
        tick(3);
        rd(2'd1, d); check("R4 stopped hold", d, 16'h0010);
        wr(2'd0, 1'b1, 16'hA520);
        tick(5);
        rd(2'd1, d); check("R4 increment", d, 16'h0015);

        // R5 interval wrap, no flag
        wr(2'd0, 1'b1, 16'h5AFE);
        tick(3);
        rd(2'd1, d); check("R5 interval wrap", d, 16'h0001);
        rd(2'd0, d); check("R5 interval ctrl kept", d, 16'h0020);
        rd(2'd2, d); check("R5 no flag interval", d, 16'h001F);

        // R5/R8 watchdog overflow, reset disabled
        wr(2'd0, 1'b1, 16'hA560);
        wr(2'd0, 1'b1, 16'h5AFF);
        tick(1);
        width = 0;
        for (int i = 0; i < 8; i++) begin
            if (wdt_rst_o) width++;
            @(negedge clk);
        end
        check("R8 no pulse", 16'(width), 16'd0);
        rd(2'd1, d); check("R8 cnt cleared", d, 16'h0000);
        rd(2'd0, d); check("R8 ctrl cleared", d, 16'h0000);

        // R6 clear protocol
        wr(2'd2, 1'b1, 16'h0000);
        rd(2'd2, d); check("R6 flag kept without read", d, 16'h009F);
        wr(2'd2, 1'b1, 16'h0000);
        rd(2'd2, d); check("R6 flag cleared after read", d, 16'h001F);

        // R7 reset pulse width
        wr(2'd2, 1'b1, 16'h0040);
        wr(2'd0, 1'b1, 16'hA560);
        wr(2'd0, 1'b1, 16'h5AFF);
        check("R7 low before", {15'b0, wdt_rst_o}, 16'h0000);
        tick(1);
        width = 0;
        for (int i = 0; i < 12; i++) begin
            if (wdt_rst_o) width++;
            @(negedge clk);
        end
        check("R7 pulse width", 16'(width), 16'(PLEN));
        rd(2'd2, d); check("R7 flag and enable", d, 16'h00DF);
        rd(2'd0, d); check("R8 ctrl cleared with reset", d, 16'h0000);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule